// File: doc/BRIEF.md
# Character glyph column sequencer

This block turns one 8-bit character code into a short timed light pattern for a column-scanned dot display. A code arrives on a single-cycle valid strobe. If the code is one of the supported symbols, the block plays that symbol's glyph on an 8-bit column port. A glyph is five column bit patterns shown one after another, each held for one delay period. After the fifth pattern the port goes dark and stays dark for a longer gap.

The supported symbols are the lower-case vowels and the ten decimal digits. The glyph table is built into the block. Upper-case letters, other characters and any other byte value are ignored. A busy output is high for the whole playback, blank gap included. Any strobe that arrives while busy is high is discarded. Parameters set the delay period in clock cycles and the length of the dark gap in periods, so a simulation can use a very short period while hardware uses a long one.

Top module: `glyph_col_seq`

## Requirements
- R1: When `code_valid` is high, `busy` is low and `code_in` is one of the ASCII values 0x61, 0x65, 0x69, 0x6F, 0x75 or 0x30 to 0x39, the next clock edge raises `busy` and drives the glyph's first column onto `col_out`.
- R2: The five columns of a glyph appear in table order, each held for exactly PERIOD_CYCLES clock cycles.
- R3: After the fifth column, `col_out` is 0x00 for BLANK_PERIODS × PERIOD_CYCLES cycles while `busy` stays high. `busy` is then low, so it is high for exactly (5 + BLANK_PERIODS) × PERIOD_CYCLES cycles per glyph.
- R4: Code 0x61 plays 3F 48 48 48 3F. Code 0x65 plays 7F 49 49 49 49.
- R5: Codes 0x6F and 0x30 play the same glyph, 3E 41 41 41 3E.
- R6: Code 0x31 plays 00 00 7F 00 00 and code 0x38 plays 36 49 49 49 36. The other glyphs are:
  - 0x69: 41 41 7F 41 41
  - 0x75: 7E 01 01 01 7E
  - 0x32: 21 43 45 49 31
  - 0x33: 22 41 49 49 36
  - 0x34: 04 0B 14 24 7F
  - 0x35: 79 49 49 49 46
  - 0x36: 3E 49 49 49 26
  - 0x37: 41 42 4C 48 68
  - 0x39: 32 49 49 49 3E
- R7: A strobe with any other code value leaves `busy` low and `col_out` at 0x00.
- R8: A strobe while `busy` is high is dropped. This includes a strobe in the last busy cycle. The playback in progress is unchanged, and no new glyph starts.
- R9: Reset, asserted low and asynchronous, forces `col_out` to 0x00 and `busy` low, and abandons any playback.
- R10: A strobe in the first cycle after `busy` falls is accepted.
- R11: `col_out` is 0x00 whenever `busy` is low, and it changes only while a glyph is playing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| code_valid | input | 1 | One-cycle strobe that marks `code_in` as valid |
| code_in | input | CODE_W | Character code (ASCII in the low byte) |
| col_out | output | 8 | Column bit pattern for the display |
| busy | output | 1 | High while a glyph, including its dark gap, is playing |

## Verification
The bench builds the block with PERIOD_CYCLES = 3 and BLANK_PERIODS = 4, so one glyph lasts only 27 cycles. At that length every glyph in the table can be played back to back, the column hold boundaries can be checked, and a strobe can be placed exactly in the last busy cycle. A period above one also exercises the counter variant of the period timer rather than its single-cycle variant. The short glyph leaves room for unsupported codes and for a reset in the middle of playback, all well inside the run length.

// File: rtl/glyph_seq_pkg.sv
package glyph_seq_pkg;

   localparam int GLYPH_COLS = 5;
   localparam int COL_BITS   = 8;

   typedef logic [COL_BITS-1:0] col_t;
   typedef col_t [GLYPH_COLS-1:0] glyph_t;   // element 0 is shown first

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_COLS,
      ST_BLANK
   } seq_state_t;

   function automatic glyph_t make_glyph(col_t c0, col_t c1, col_t c2, col_t c3, col_t c4);
      glyph_t g;
      g[0] = c0;
      g[1] = c1;
      g[2] = c2;
      g[3] = c3;
      g[4] = c4;
      return g;
   endfunction

endpackage

// File: rtl/glyph_font_rom.sv
module glyph_font_rom
   import glyph_seq_pkg::*;
#(
   parameter int CODE_W = 8
) (
   input  logic [CODE_W-1:0] code,
   output glyph_t            glyph,
   output logic              hit
);

   logic [7:0] code_byte;
   logic       upper_zero;
   logic       byte_hit;

   assign code_byte = code[7:0];

   // Wider codes only match when the bits above the byte are clear.
   generate
      if (CODE_W > 8) begin : g_wide
         assign upper_zero = ~|code[CODE_W-1:8];
      end else begin : g_byte
         assign upper_zero = 1'b1;
      end
   endgenerate

   always_comb begin
      byte_hit = 1'b1;
      case (code_byte)
         8'h61:        glyph = make_glyph(8'h3F, 8'h48, 8'h48, 8'h48, 8'h3F);
         8'h65:        glyph = make_glyph(8'h7F, 8'h49, 8'h49, 8'h49, 8'h49);
         8'h69:        glyph = make_glyph(8'h41, 8'h41, 8'h7F, 8'h41, 8'h41);
         8'h75:        glyph = make_glyph(8'h7E, 8'h01, 8'h01, 8'h01, 8'h7E);
         8'h6F, 8'h30: glyph = make_glyph(8'h3E, 8'h41, 8'h41, 8'h41, 8'h3E);
         8'h31:        glyph = make_glyph(8'h00, 8'h00, 8'h7F, 8'h00, 8'h00);
         8'h32:        glyph = make_glyph(8'h21, 8'h43, 8'h45, 8'h49, 8'h31);
         8'h33:        glyph = make_glyph(8'h22, 8'h41, 8'h49, 8'h49, 8'h36);
         8'h34:        glyph = make_glyph(8'h04, 8'h0B, 8'h14, 8'h24, 8'h7F);
         8'h35:        glyph = make_glyph(8'h79, 8'h49, 8'h49, 8'h49, 8'h46);
         8'h36:        glyph = make_glyph(8'h3E, 8'h49, 8'h49, 8'h49, 8'h26);
         8'h37:        glyph = make_glyph(8'h41, 8'h42, 8'h4C, 8'h48, 8'h68);
         8'h38:        glyph = make_glyph(8'h36, 8'h49, 8'h49, 8'h49, 8'h36);
         8'h39:        glyph = make_glyph(8'h32, 8'h49, 8'h49, 8'h49, 8'h3E);
         default: begin
            glyph    = '0;
            byte_hit = 1'b0;
         end
      endcase
   end

   assign hit = byte_hit & upper_zero;

endmodule

// File: rtl/glyph_period_timer.sv
module glyph_period_timer #(
   parameter int PERIOD_CYCLES = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   output logic tick
);

   generate
      if (PERIOD_CYCLES == 1) begin : g_single
         // Every running cycle ends a period, so no counter is needed.
         logic unused_inputs;
         assign unused_inputs = clk ^ rst_n ^ restart;
         assign tick          = run;
      end else begin : g_count
         localparam int CNT_W = $clog2(PERIOD_CYCLES);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYCLES - 1);

         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (restart) begin
               cnt_q <= '0;
            end else if (run) begin
               cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
            end
         end

         assign tick = run && (cnt_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/glyph_col_seq.sv
module glyph_col_seq
   import glyph_seq_pkg::*;
#(
   parameter int CODE_W        = 8,
   parameter int PERIOD_CYCLES = 1024,
   parameter int BLANK_PERIODS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              code_valid,
   input  logic [CODE_W-1:0] code_in,
   output logic [7:0]        col_out,
   output logic              busy
);

   localparam int SLOT_MAX = (GLYPH_COLS > BLANK_PERIODS) ? GLYPH_COLS : BLANK_PERIODS;
   localparam int SLOT_W   = (SLOT_MAX > 1) ? $clog2(SLOT_MAX) : 1;
   localparam logic [SLOT_W-1:0] LAST_COL   = SLOT_W'(GLYPH_COLS - 1);
   localparam logic [SLOT_W-1:0] LAST_BLANK = SLOT_W'(BLANK_PERIODS - 1);

   generate
      if (PERIOD_CYCLES < 1) begin : g_bad_period
         $error("glyph_col_seq: PERIOD_CYCLES must be at least 1");
      end
      if (BLANK_PERIODS < 1) begin : g_bad_blank
         $error("glyph_col_seq: BLANK_PERIODS must be at least 1");
      end
      if (CODE_W < 8) begin : g_bad_code
         $error("glyph_col_seq: CODE_W must hold an 8-bit character");
      end
      if (COL_BITS != 8) begin : g_bad_col
         $error("glyph_col_seq: column width must match the 8-bit port");
      end
   endgenerate

   seq_state_t        state_q;
   logic [SLOT_W-1:0] slot_q;
   logic [SLOT_W-1:0] slot_inc;
   glyph_t            glyph_q;
   glyph_t            rom_glyph;
   logic              rom_hit;
   logic              accept;
   logic              tick;
   col_t              next_col;

   glyph_font_rom #(
      .CODE_W (CODE_W)
   ) u_rom (
      .code  (code_in),
      .glyph (rom_glyph),
      .hit   (rom_hit)
   );

   assign accept = (state_q == ST_IDLE) && code_valid && rom_hit;

   glyph_period_timer #(
      .PERIOD_CYCLES (PERIOD_CYCLES)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (accept),
      .run     (state_q != ST_IDLE),
      .tick    (tick)
   );

   assign slot_inc = slot_q + SLOT_W'(1);

   // The column that follows the current slot.
   always_comb begin
      next_col = '0;
      for (int i = 0; i < GLYPH_COLS; i++) begin
         if (slot_inc == SLOT_W'(i)) next_col = glyph_q[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         slot_q  <= '0;
         glyph_q <= '0;
         col_out <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q <= ST_COLS;
                  slot_q  <= '0;
                  glyph_q <= rom_glyph;
                  col_out <= rom_glyph[0];
               end
            end
            ST_COLS: begin
               if (tick) begin
                  if (slot_q == LAST_COL) begin
                     state_q <= ST_BLANK;
                     slot_q  <= '0;
                     col_out <= '0;
                  end else begin
                     slot_q  <= slot_inc;
                     col_out <= next_col;
                  end
               end
            end
            ST_BLANK: begin
               if (tick) begin
                  if (slot_q == LAST_BLANK) begin
                     state_q <= ST_IDLE;
                     slot_q  <= '0;
                  end else begin
                     slot_q <= slot_inc;
                  end
               end
            end
            default: begin
               state_q <= ST_IDLE;
               slot_q  <= '0;
               col_out <= '0;
            end
         endcase
      end
   end

   assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/glyph_col_seq_chk.sv
module glyph_col_seq_chk #(
   parameter int CODE_W        = 8,
   parameter int PERIOD_CYCLES = 1024,
   parameter int BLANK_PERIODS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              code_valid,
   input logic [CODE_W-1:0] code_in,
   input logic [7:0]        col_out,
   input logic              busy
);

   localparam int TOTAL = (5 + BLANK_PERIODS) * PERIOD_CYCLES;

   logic sym_hit;
   int   run_len;

   always_comb begin
      sym_hit = 1'b0;
      if (CODE_W == 8 || (code_in >> 8) == '0) begin
         case (code_in[7:0])
            8'h61, 8'h65, 8'h69, 8'h6F, 8'h75: sym_hit = 1'b1;
            default: sym_hit = (code_in[7:0] >= 8'h30) && (code_in[7:0] <= 8'h39);
         endcase
      end
   end

   // Number of busy cycles seen so far in the current playback.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_len <= 0;
      else if (busy) run_len <= run_len + 1;
      else           run_len <= 0;
   end

   a_r1_start_from_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(code_valid) && $past(sym_hit)));

   a_r7_unsupported_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && code_valid && !sym_hit) |=> !busy);

   a_r3_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && run_len < TOTAL - 1) |=> busy);

   a_r3_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_len == TOTAL));

   a_r2_change_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$stable(col_out)) |-> ((run_len % PERIOD_CYCLES) == 0));

   a_r11_idle_port_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (col_out == 8'h00));

   a_r11_change_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(col_out) |-> busy);

endmodule

bind glyph_col_seq glyph_col_seq_chk #(
   .CODE_W        (CODE_W),
   .PERIOD_CYCLES (PERIOD_CYCLES),
   .BLANK_PERIODS (BLANK_PERIODS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .code_valid (code_valid),
   .code_in    (code_in),
   .col_out    (col_out),
   .busy       (busy)
);

// File: tb/glyph_col_seq_test.sv
module glyph_col_seq_test;

   localparam int P     = 3;
   localparam int B     = 4;
   localparam int TOTAL = (5 + B) * P;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       code_valid = 1'b0;
   logic [7:0] code_in = 8'h00;
   logic [7:0] col_out;
   logic       busy;

   int    n_checks = 0;
   int    n_fail = 0;
   int    cyc = 0;
   string cur_req = "R9";

   always #10 clk = ~clk;   // 50 MHz

   glyph_col_seq #(
      .CODE_W        (8),
      .PERIOD_CYCLES (P),
      .BLANK_PERIODS (B)
   ) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .code_valid (code_valid),
      .code_in    (code_in),
      .col_out    (col_out),
      .busy       (busy)
   );

   function automatic logic [4:0][7:0] pk(logic [7:0] c0, logic [7:0] c1, logic [7:0] c2,
                                          logic [7:0] c3, logic [7:0] c4);
      return {c4, c3, c2, c1, c0};
   endfunction

   function automatic bit ref_glyph(input logic [7:0] c, output logic [4:0][7:0] g);
      g = '0;
      case (c)
         8'h61: g = pk(8'h3F, 8'h48, 8'h48, 8'h48, 8'h3F);
         8'h65: g = pk(8'h7F, 8'h49, 8'h49, 8'h49, 8'h49);
         8'h69: g = pk(8'h41, 8'h41, 8'h7F, 8'h41, 8'h41);
         8'h75: g = pk(8'h7E, 8'h01, 8'h01, 8'h01, 8'h7E);
         8'h6F: g = pk(8'h3E, 8'h41, 8'h41, 8'h41, 8'h3E);
         8'h30: g = pk(8'h3E, 8'h41, 8'h41, 8'h41, 8'h3E);
         8'h31: g = pk(8'h00, 8'h00, 8'h7F, 8'h00, 8'h00);
         8'h32: g = pk(8'h21, 8'h43, 8'h45, 8'h49, 8'h31);
         8'h33: g = pk(8'h22, 8'h41, 8'h49, 8'h49, 8'h36);
         8'h34: g = pk(8'h04, 8'h0B, 8'h14, 8'h24, 8'h7F);
         8'h35: g = pk(8'h79, 8'h49, 8'h49, 8'h49, 8'h46);
         8'h36: g = pk(8'h3E, 8'h49, 8'h49, 8'h49, 8'h26);
         8'h37: g = pk(8'h41, 8'h42, 8'h4C, 8'h48, 8'h68);
         8'h38: g = pk(8'h36, 8'h49, 8'h49, 8'h49, 8'h36);
         8'h39: g = pk(8'h32, 8'h49, 8'h49, 8'h49, 8'h3E);
         default: return 1'b0;
      endcase
      return 1'b1;
   endfunction

   // Reference model: a queue holding one expected port value per busy cycle.
   logic [7:0]      expq[$];
   logic [7:0]      exp_col = 8'h00;
   logic            exp_busy = 1'b0;
   logic [4:0][7:0] mg;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         expq.delete();
      end else if (expq.size() == 0) begin
         if (code_valid && ref_glyph(code_in, mg)) begin
            for (int k = 0; k < 5; k++)
               for (int p = 0; p < P; p++) expq.push_back(mg[k]);
            for (int z = 0; z < B * P; z++) expq.push_back(8'h00);
         end
      end else begin
         void'(expq.pop_front());
      end
      exp_busy = (expq.size() > 0);
      exp_col  = exp_busy ? expq[0] : 8'h00;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         n_checks++;
         if (busy !== exp_busy) begin
            n_fail++;
            $display("FAIL %s per-cycle busy: actual %0b expected %0b", cur_req, busy, exp_busy);
         end
         n_checks++;
         if (col_out !== exp_col) begin
            n_fail++;
            $display("FAIL %s per-cycle col_out: actual 0x%02h expected 0x%02h", cur_req, col_out, exp_col);
         end
      end
   end

   task automatic summary();
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 20000) begin
         n_fail++;
         $display("FAIL R3 watchdog: actual %0d cycles expected fewer than 20000", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(string tag, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // Strobe one code at a negedge and follow the playback to its end.
   task automatic play(logic [7:0] c, string req, int intrude_at, logic [7:0] ic);
      logic [4:0][7:0] g;
      int n;
      void'(ref_glyph(c, g));
      cur_req    = req;
      code_in    = c;
      code_valid = 1'b1;
      @(negedge clk);
      code_valid = 1'b0;
      chk({"R1 busy after strobe (", req, ")"}, busy, 1);
      chk({"R1 first column (", req, ")"}, col_out, g[0]);
      n = 0;
      while (busy) begin
         n++;
         if ((n - 1) % P == 0 && (n - 1) / P < 5)
            chk({"R2 column order/hold (", req, ")"}, col_out, g[(n - 1) / P]);
         if (n == 5 * P + 1)
            chk("R3 blank after fifth column", col_out, 0);
         if (n == intrude_at) begin
            code_in    = ic;
            code_valid = 1'b1;
         end else begin
            code_valid = 1'b0;
         end
         @(negedge clk);
      end
      code_valid = 1'b0;
      chk({"R3 busy length (", req, ")"}, n, TOTAL);
   endtask

   initial begin
      logic [7:0] bad_codes [6];
      bad_codes = '{8'h62, 8'h41, 8'h5A, 8'h00, 8'hFF, 8'h4F};

      // R9: reset state
      repeat (3) @(negedge clk);
      chk("R9 reset busy", busy, 0);
      chk("R9 reset col_out", col_out, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 after release busy", busy, 0);
      chk("R11 idle col_out", col_out, 0);

      play(8'h61, "R4", 0, 8'h00);
      repeat (2) @(negedge clk);
      play(8'h65, "R4", 0, 8'h00);
      repeat (2) @(negedge clk);
      play(8'h6F, "R5", 0, 8'h00);
      play(8'h30, "R10", 0, 8'h00);   // back to back: strobe in first idle cycle
      play(8'h31, "R6", 0, 8'h00);
      play(8'h38, "R6", 0, 8'h00);
      play(8'h69, "R6", 0, 8'h00);
      play(8'h75, "R6", 0, 8'h00);
      for (int d = 2; d <= 9; d++) begin
         if (d != 8) play(8'h30 + 8'(d), "R6", 0, 8'h00);
      end

      // R8: strobes while busy, mid-glyph and in the last busy cycle
      repeat (2) @(negedge clk);
      play(8'h38, "R8", 5, 8'h61);
      play(8'h32, "R8", TOTAL, 8'h65);
      chk("R8 late strobe dropped busy", busy, 0);
      chk("R8 late strobe dropped col_out", col_out, 0);
      @(negedge clk);
      chk("R8 still idle after drop", busy, 0);

      // R7: unsupported codes
      cur_req = "R7";
      foreach (bad_codes[i]) begin
         code_in    = bad_codes[i];
         code_valid = 1'b1;
         @(negedge clk);
         code_valid = 1'b0;
         chk("R7 unsupported busy", busy, 0);
         chk("R7 unsupported col_out", col_out, 0);
         @(negedge clk);
         chk("R7 unsupported still idle", busy, 0);
      end

      // R9: reset in the middle of a glyph
      cur_req    = "R9";
      code_in    = 8'h34;
      code_valid = 1'b1;
      @(negedge clk);
      code_valid = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R9 mid-play reset busy", busy, 0);
      chk("R9 mid-play reset col_out", col_out, 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R9 idle after reset", busy, 0);
      play(8'h39, "R1", 0, 8'h00);

      repeat (3) @(negedge clk);
      summary();
      $finish;
   end

endmodule